// File: doc/BRIEF.md
# GF(2^113) Fermat-Chain Inverter

This block returns the multiplicative inverse of a nonzero element of the binary field GF(2^113). Elements use polynomial basis with the reduction trinomial x^113 + x^9 + 1. The inverse is computed as a^(2^113 - 2), which the Fermat identity guarantees. A fixed square-and-multiply addition chain evaluates this power. The chain first builds a^(2^k - 1) for k = 1, 2, 3, 6, 7, 14, 28, 56 and 112. It then applies one last squaring.

The block accepts one operand at a time through a valid/ready handshake. It works on that operand alone until the result is ready. Squaring is a single combinational step per clock. Multiplication uses a digit-serial unit that consumes `DIGIT_W` bits of one operand per cycle. A small sequencer steps through the chain and drives the datapath with a struct of strobes. The result is presented together with a one-cycle done strobe. It stays on the output until the next operand is taken.

Top module: `inv_itoh_tsujii`

## Requirements
- R1: After reset is released, `inReady` is 1 and `outDone` is 0.
- R2: An operand is taken on a clock edge where `inValid` and `inReady` are both 1. `inReady` is 0 from the next cycle until the cycle that carries `outDone`, and it is 1 again in the cycle after that.
- R3: `outResult` in the done cycle, multiplied by the accepted operand modulo x^113 + x^9 + 1, gives 1. Bit i of every 113-bit vector is the coefficient of x^i.
- R4: `outDone` is high for exactly one cycle per accepted operand, and never otherwise.
- R5: `outDone` rises a fixed number of cycles after acceptance. That number is 111 squaring cycles, plus 8 multiplications of ceil(113/DIGIT_W)+2 cycles each, plus 2. With DIGIT_W = 8, `outDone` is high in the 249th cycle after the accepting edge.
- R6: While an inversion runs, `inValid` and `inOperand` are ignored, and the result still belongs to the operand that was accepted.
- R7: `outResult` keeps its done-cycle value until the next operand is accepted.
- R8: The operand 1 returns 1. The single-term operands x, x^9 and x^112 return their true inverses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand present |
| inReady | output | 1 | Block idle and able to take an operand |
| inOperand | input | 113 | Field element to invert, nonzero |
| outResult | output | 113 | Inverse of the last accepted operand |
| outDone | output | 1 | One-cycle strobe marking a fresh result |

## Verification
The assertions assume every accepted operand is nonzero. A zero operand follows the same chain but yields zero, and no property claims otherwise. They make no assumption about `inValid` while busy, so noise on the inputs during a run is legal and is exercised on purpose. The stimulus makes random operands nonzero by setting bit 0 of any all-zero draw. It drops the noisy `inValid` well before the run can finish, so no second operand is taken by accident.

// File: rtl/inv_pkg.sv
package inv_pkg;

  localparam int FIELD_M  = 113;
  localparam int POLY_K   = 9;
  localparam int DIGIT_W  = 8;
  localparam int N_STEPS  = 8;
  localparam int STEP_W   = $clog2(N_STEPS);
  localparam int SQCNT_W  = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SQR,
    ST_MULGO,
    ST_MULWAIT,
    ST_FIN,
    ST_DONE
  } invState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic loadOp;
    logic sqEn;
    logic saveEn;
    logic mulGo;
    logic mulUseA;
    logic mulLoad;
  } dpCtrl_t;

  // squarings per chain step; chain builds exponents of 2^k-1 ones for
  // k = 2,3,6,7,14,28,56,112 (tied to degree 113)
  function automatic logic [SQCNT_W-1:0] stepSquares(input logic [STEP_W-1:0] idx);
    case (idx)
      3'd0:    return 6'd1;
      3'd1:    return 6'd1;
      3'd2:    return 6'd3;
      3'd3:    return 6'd1;
      3'd4:    return 6'd7;
      3'd5:    return 6'd14;
      3'd6:    return 6'd28;
      default: return 6'd56;
    endcase
  endfunction

  // steps that add a single one multiply by the original operand,
  // the doubling steps multiply by the value saved before squaring
  function automatic logic stepUsesA(input logic [STEP_W-1:0] idx);
    return (idx == 3'd1) || (idx == 3'd3);
  endfunction

endpackage

// File: rtl/inv_gf_mul.sv
module inv_gf_mul #(
  parameter int M = inv_pkg::FIELD_M,
  parameter int K = inv_pkg::POLY_K,
  parameter int D = inv_pkg::DIGIT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [M-1:0] opX,
  input  logic [M-1:0] opY,
  output logic [M-1:0] prod,
  output logic         done
);

  localparam int NDIG = (M + D - 1) / D;
  localparam int PADW = NDIG * D;
  localparam int CW   = $clog2(NDIG + 1);

  logic [M-1:0]    xReg, pReg, pNext;
  logic [PADW-1:0] yReg;
  logic [CW-1:0]   cnt;

  function automatic logic [M-1:0] xtime(input logic [M-1:0] v);
    logic [M-1:0] r;
    r = {v[M-2:0], 1'b0};
    if (v[M-1]) begin
      r[0] = r[0] ^ 1'b1;
      r[K] = r[K] ^ 1'b1;
    end
    return r;
  endfunction

  // Horner step over one digit of Y, most significant bit first
  always_comb begin
    pNext = pReg;
    for (int j = D - 1; j >= 0; j--) begin
      pNext = xtime(pNext) ^ (yReg[PADW-D+j] ? xReg : '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xReg <= '0;
      yReg <= '0;
      pReg <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else if (start) begin
      xReg <= opX;
      yReg <= PADW'(opY);
      pReg <= '0;
      cnt  <= CW'(NDIG);
      done <= 1'b0;
    end else if (cnt != '0) begin
      pReg <= pNext;
      yReg <= yReg << D;
      cnt  <= cnt - 1'b1;
      done <= (cnt == CW'(1));
    end else begin
      done <= 1'b0;
    end
  end

  assign prod = pReg;

  // R5: a new product is only started on an idle multiplier
  p_start_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    start |-> (cnt == '0));

  // R5: completion strobe lasts one cycle
  p_mul_done_once_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/inv_datapath.sv
module inv_datapath
  import inv_pkg::*;
#(
  parameter int M = FIELD_M,
  parameter int K = POLY_K,
  parameter int D = DIGIT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCtrl_t      ctl,
  input  logic [M-1:0] inOperand,
  output logic [M-1:0] result,
  output logic         mulDone
);

  logic [M-1:0] opReg, accReg, saveReg, sqOut, mulY, mulProd;

  function automatic logic [M-1:0] gfSquare(input logic [M-1:0] v);
    logic [2*M-2:0] w;
    w = '0;
    for (int i = 0; i < M; i++) w[2*i] = v[i];
    for (int i = 2*M-2; i >= M; i--) begin
      if (w[i]) begin
        w[i]       = 1'b0;
        w[i-M+K]   = w[i-M+K] ^ 1'b1;
        w[i-M]     = w[i-M] ^ 1'b1;
      end
    end
    return w[M-1:0];
  endfunction

  assign sqOut = gfSquare(accReg);
  assign mulY  = ctl.mulUseA ? opReg : saveReg;

  inv_gf_mul #(.M(M), .K(K), .D(D)) mulUnit (
    .clk   (clk),
    .rstN  (rstN),
    .start (ctl.mulGo),
    .opX   (accReg),
    .opY   (mulY),
    .prod  (mulProd),
    .done  (mulDone)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg   <= '0;
      accReg  <= '0;
      saveReg <= '0;
    end else begin
      if (ctl.loadOp) begin
        opReg  <= inOperand;
        accReg <= inOperand;
      end else if (ctl.sqEn) begin
        accReg <= sqOut;
      end else if (ctl.mulLoad) begin
        accReg <= mulProd;
      end
      if (ctl.saveEn) saveReg <= accReg;
    end
  end

  assign result = accReg;

  // R3: at most one source writes the accumulator in any cycle
  p_one_writer_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadOp, ctl.sqEn, ctl.mulLoad}));

  // R3: a product is only taken once the multiplier reports completion
  p_load_after_mul_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.mulLoad |-> mulDone);

endmodule

// File: rtl/inv_ctrl.sv
module inv_ctrl
  import inv_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    mulDone,
  output logic    inReady,
  output logic    outDone,
  output dpCtrl_t ctl
);

  invState_t            state;
  logic [STEP_W-1:0]    stepIdx;
  logic [SQCNT_W-1:0]   sqCnt;
  logic                 lastSq;

  assign lastSq = (sqCnt == stepSquares(stepIdx) - 6'd1);

  always_comb begin
    ctl     = '0;
    inReady = 1'b0;
    outDone = 1'b0;
    case (state)
      ST_IDLE: begin
        inReady    = 1'b1;
        ctl.loadOp = inValid;
      end
      ST_SQR: begin
        ctl.sqEn   = 1'b1;
        ctl.saveEn = (sqCnt == '0);
      end
      ST_MULGO: begin
        ctl.mulGo   = 1'b1;
        ctl.mulUseA = stepUsesA(stepIdx);
      end
      ST_MULWAIT: ctl.mulLoad = mulDone;
      ST_FIN:     ctl.sqEn    = 1'b1;
      ST_DONE:    outDone     = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepIdx <= '0;
      sqCnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (inValid) begin
          state   <= ST_SQR;
          stepIdx <= '0;
          sqCnt   <= '0;
        end
        ST_SQR: begin
          if (lastSq) begin
            sqCnt <= '0;
            state <= ST_MULGO;
          end else begin
            sqCnt <= sqCnt + 1'b1;
          end
        end
        ST_MULGO: state <= ST_MULWAIT;
        ST_MULWAIT: if (mulDone) begin
          if (stepIdx == STEP_W'(N_STEPS - 1)) begin
            state <= ST_FIN;
          end else begin
            stepIdx <= stepIdx + 1'b1;
            state   <= ST_SQR;
          end
        end
        ST_FIN:  state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: taking an operand closes the handshake on the next cycle
  p_accept_drop_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R2: the block is idle again right after the done cycle
  p_ready_after_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    outDone |=> inReady);

  // R4: done strobe is a single cycle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    outDone |=> !outDone);

  // R5: a squaring run never exceeds its step length
  p_sq_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SQR) |-> (sqCnt < stepSquares(stepIdx)));

endmodule

// File: rtl/inv_itoh_tsujii.sv
module inv_itoh_tsujii #(
  parameter int M = inv_pkg::FIELD_M,
  parameter int K = inv_pkg::POLY_K,
  parameter int D = inv_pkg::DIGIT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output logic         inReady,
  input  logic [M-1:0] inOperand,
  output logic [M-1:0] outResult,
  output logic         outDone
);

  inv_pkg::dpCtrl_t ctl;
  logic             mulDone;

  inv_ctrl seq (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .mulDone (mulDone),
    .inReady (inReady),
    .outDone (outDone),
    .ctl     (ctl)
  );

  inv_datapath #(.M(M), .K(K), .D(D)) dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .inOperand (inOperand),
    .result    (outResult),
    .mulDone   (mulDone)
  );

  // R7: result does not move in the cycle after done
  p_hold_result_r7: assert property (@(posedge clk) disable iff (!rstN)
    outDone |=> $stable(outResult));

  // R7: while idle with no operand offered, the result is held
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && !inValid) |=> $stable(outResult));

endmodule

// File: tb/inv_itoh_tsujii_test.sv
`timescale 1ns/1ps
module inv_itoh_tsujii_test;

  localparam int M       = 113;
  localparam int D       = 8;
  localparam int NDIG    = (M + D - 1) / D;
  localparam int EXP_LAT = 111 + 8 * (NDIG + 2) + 2;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [M-1:0] inOperand = '0;
  logic         inReady, outDone;
  logic [M-1:0] outResult;

  always #2 clk = ~clk;

  inv_itoh_tsujii #(.M(M), .K(9), .D(D)) uut (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inReady   (inReady),
    .inOperand (inOperand),
    .outResult (outResult),
    .outDone   (outDone)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [M-1:0] expQ[$];
  string        tagQ[$];

  // monitor state
  bit           inFlight = 1'b0;
  int           latCnt = 0;
  bit           readyBad = 1'b0;
  bit           expectReady = 1'b0;
  bit           holdValid = 1'b0;
  bit           holdBad = 1'b0;
  logic [M-1:0] heldVal = '0;

  function automatic logic [M-1:0] refMul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [2*M-1:0] full;
    logic [2*M-1:0] poly;
    full = '0;
    poly = '0;
    poly[M] = 1'b1;
    poly[9] = 1'b1;
    poly[0] = 1'b1;
    for (int i = 0; i < M; i++)
      if (b[i]) full = full ^ ({{M{1'b0}}, a} << i);
    for (int i = 2*M-2; i >= M; i--)
      if (full[i]) full = full ^ (poly << (i - M));
    return full[M-1:0];
  endfunction

  function automatic logic [M-1:0] rndOp();
    logic [127:0] w;
    w = {$urandom, $urandom, $urandom, $urandom};
    if (w[M-1:0] == '0) w[0] = 1'b1;
    return w[M-1:0];
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [M-1:0] act, input logic [M-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor: samples at the falling edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (expectReady) begin
        check(inReady == 1'b1, "R2", "ready after done", M'(inReady), M'(1));
        check(outDone == 1'b0, "R4", "done longer than one cycle", M'(outDone), M'(0));
        expectReady = 1'b0;
      end
      if (holdValid && outResult !== heldVal) holdBad = 1'b1;
      if (inFlight) begin
        latCnt++;
        if (outDone) begin
          logic [M-1:0] op;
          string        tag;
          if (expQ.size() == 0) begin
            check(1'b0, "R4", "done without queued operand", M'(1), M'(0));
          end else begin
            op  = expQ.pop_front();
            tag = tagQ.pop_front();
            check(refMul(op, outResult) == M'(1), tag, "a*inv(a)",
                  refMul(op, outResult), M'(1));
          end
          check(latCnt == EXP_LAT, "R5", "latency", M'(latCnt), M'(EXP_LAT));
          check(!readyBad, "R2", "ready low while busy", M'(readyBad), M'(0));
          inFlight    = 1'b0;
          expectReady = 1'b1;
          readyBad    = 1'b0;
          heldVal     = outResult;
          holdValid   = 1'b1;
          holdBad     = 1'b0;
        end else if (inReady) begin
          readyBad = 1'b1;
        end
      end else if (outDone) begin
        check(1'b0, "R4", "unexpected done", M'(1), M'(0));
      end
      if (inValid && inReady) begin
        if (holdValid) begin
          check(!holdBad, "R7", "result held until next accept", M'(holdBad), M'(0));
          holdValid = 1'b0;
        end
        inFlight = 1'b1;
        latCnt   = 0;
      end
    end
  end

  // driver: offers one operand, optionally with input noise while busy
  task automatic applyOp(input logic [M-1:0] op, input string tag, input bit noise);
    @(posedge clk); #1;
    inValid   = 1'b1;
    inOperand = op;
    do @(negedge clk); while (!inReady);
    expQ.push_back(op);
    tagQ.push_back(tag);
    @(posedge clk); #1;
    if (noise) begin
      for (int i = 0; i < 100; i++) begin
        inOperand = rndOp();
        inValid   = 1'b1;
        @(posedge clk); #1;
      end
    end
    inValid   = 1'b0;
    inOperand = '0;
    do @(negedge clk); while (!outDone);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R1", "ready after reset", M'(inReady), M'(1));
    check(outDone == 1'b0, "R1", "done after reset", M'(outDone), M'(0));

    applyOp(M'(1), "R8", 1'b0);
    check(outResult == M'(1), "R8", "inverse of one", outResult, M'(1));
    applyOp(M'(1) << 1, "R8", 1'b0);
    applyOp(M'(1) << 9, "R8", 1'b0);
    applyOp(M'(1) << 112, "R8", 1'b0);
    applyOp({M{1'b1}}, "R3", 1'b0);
    for (int v = 0; v < 16; v++) applyOp(rndOp(), "R3", 1'b0);
    for (int v = 0; v < 4; v++)  applyOp(rndOp(), "R6", 1'b1);

    repeat (10) @(negedge clk);
    check(holdValid && !holdBad, "R7", "final result held", M'(holdBad), M'(0));

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nFails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule